// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a clocked host to an external asynchronous byte-wide static RAM with 2^18 locations. The host raises a request strobe together with a read/write select, an address and, for writes, a data byte. The request is taken only while `ready_o` is high. The block then runs the strobe sequence on the memory pins and returns to its parked state. At the end of a read it presents the captured byte with a one-cycle valid pulse.

All memory strobes are active low and come from registers, so they cannot glitch. While the block is parked, chip enable, write enable and output enable are all high and the data bus is released. Two parameters set the length of the read access and of the write strobe in clock cycles. Each must be at least the memory's cycle time divided by the clock period, rounded up. The bus is driven only after output enable has been high for at least two cycles, so the controller and the memory never drive it at the same time.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset, and whenever no access is running, chip enable, write enable and output enable are high (1), the data bus output enable is low (0), `ready_o` is 1 and `rvalid_o` is 0.
- R2: A read holds chip enable low, output enable low and write enable high, with the data bus released, for exactly RD_CYC cycles starting the cycle after acceptance.
- R3: The byte on `sram_dq_i` at the clock edge that ends the last read cycle appears on `rdata_o` in the following cycle, with `rvalid_o` high for exactly that one cycle. That cycle is also the first parked cycle.
- R4: A write runs, starting the cycle after acceptance: one cycle with chip enable low and write enable and output enable high; one cycle with write enable also low and the bus still released; WR_CYC cycles with write enable low and the bus driven; one cycle with write enable high, chip enable low and the bus still driven. Then it parks. Output enable stays high throughout.
- R5: The address, and the write data while driven, equal the accepted request's values for the whole access. Later changes on the host inputs do not affect them.
- R6: Write enable and output enable are never low together. The bus is never driven while output enable is low or chip enable is high.
- R7: `ready_o` is low from the cycle after acceptance until the access completes. A request presented while `ready_o` is low is not taken until `ready_o` returns high.
- R8: Every rise of the data bus output enable is preceded by at least two cycles with output enable high, including a write issued right after a read.
- R9: `rdata_o` keeps its value between read completions, across writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Host word address |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Last byte read |
| rvalid_o | output | 1 | One-cycle pulse when `rdata_o` is new |
| ready_o | output | 1 | Controller can take a request |
| sram_ce_n_o | output | 1 | Memory chip enable, active low |
| sram_we_n_o | output | 1 | Memory write enable, active low |
| sram_oe_n_o | output | 1 | Memory output enable, active low |
| sram_addr_o | output | 18 | Memory address |
| sram_dq_o | output | 8 | Data toward the memory |
| sram_dq_i | input | 8 | Data from the memory bus |
| sram_dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The bench connects a pin-level memory model that stores a byte on each rising write strobe and drives the bus only in its read mode. A write with a wrong strobe order or a missing data hold therefore reads back wrong. The bench also flags any cycle in which both the controller and the model drive the bus. It holds requests asserted with altered address, data and direction while the controller is busy. A design that latched host inputs late, or took requests while busy, would then show the wrong address or an extra access. It covers the lowest and highest addresses, unwritten locations, overwrites of the same location and a write directly after a read. A missing bus turnaround, an off-by-one in the phase counts, or a `rdata_o` that changes outside the valid pulse would each show up as a cycle mismatch against the reference sequence.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSET = 3'd2,
    ST_WWE  = 3'd3,
    ST_WDAT = 3'd4,
    ST_WHLD = 3'd5
  } seq_st_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } pin_set_t;

  localparam pin_set_t PINS_PARK = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

  function automatic pin_set_t pins_for(seq_st_e st);
    pin_set_t p;
    p = PINS_PARK;
    case (st)
      ST_RD:   p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
      ST_WSET: p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
      ST_WWE:  p = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b0};
      ST_WDAT: p = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
      ST_WHLD: p = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
      default: p = PINS_PARK;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctl_rst_sync.sv
module sram_ctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    is_wr,
  output seq_st_e st_d,
  output logic    accept,
  output logic    capture
);
  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    accept  = 1'b0;
    capture = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          st_d   = is_wr ? ST_WSET : ST_RD;
        end
      end
      ST_RD: begin
        if (cnt_q == RD_LAST) begin
          capture = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      ST_WSET: st_d = ST_WWE;
      ST_WWE:  st_d = ST_WDAT;
      ST_WDAT: if (cnt_q == WR_LAST) st_d = ST_WHLD;
      ST_WHLD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // phase counter: restarts on every state change
  always_comb begin
    cnt_en = (st_d != st_q) || (st_q == ST_RD) || (st_q == ST_WDAT);
    cnt_d  = (st_d != st_q) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  seq_st_e st_d,
  input  logic    capture,
  output logic    ce_n,
  output logic    we_n,
  output logic    oe_n,
  output logic    drv,
  output logic    ready,
  output logic    rvalid
);
  pin_set_t pins_d, pins_q;
  logic     ready_q, rvalid_q;

  always_comb pins_d = pins_for(st_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q   <= PINS_PARK;
      ready_q  <= 1'b1;
      rvalid_q <= 1'b0;
    end else begin
      pins_q   <= pins_d;
      ready_q  <= (st_d == ST_IDLE);
      rvalid_q <= capture;
    end
  end

  assign ce_n   = pins_q.ce_n;
  assign we_n   = pins_q.we_n;
  assign oe_n   = pins_q.oe_n;
  assign drv    = pins_q.drv;
  assign ready  = ready_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] bus_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture) rdata_q <= bus_i;
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW          = 18,
  parameter int DW          = 8,
  parameter int RD_CYC      = 2,
  parameter int WR_CYC      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          ready_o,
  output logic          sram_ce_n_o,
  output logic          sram_we_n_o,
  output logic          sram_oe_n_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_dq_oe_o
);
  logic    rst_n_int;
  seq_st_e st_d;
  logic    accept, capture;

  sram_ctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sram_ctl_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .req     (req_i),
    .is_wr   (wr_i),
    .st_d    (st_d),
    .accept  (accept),
    .capture (capture)
  );

  sram_ctl_pins u_pins (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .st_d    (st_d),
    .capture (capture),
    .ce_n    (sram_ce_n_o),
    .we_n    (sram_we_n_o),
    .oe_n    (sram_oe_n_o),
    .drv     (sram_dq_oe_o),
    .ready   (ready_o),
    .rvalid  (rvalid_o)
  );

  sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .accept  (accept),
    .capture (capture),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .bus_i   (sram_dq_i),
    .addr_o  (sram_addr_o),
    .wdata_o (sram_dq_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic [DW-1:0] dq_o,
  input logic [AW-1:0] addr,
  input logic          ready,
  input logic          rvalid
);
  // R6: memory outputs and write strobe never active together
  a_r6_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  // R6: controller drives only with memory outputs off and chip selected
  a_r6_drive_safe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (oe_n && !ce_n));
  // R2: output enable low only inside a selected read
  a_r2_read_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n && !dq_oe));
  // R4: write strobe only with chip selected
  a_r4_we_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);
  // R4: write strobe ends before chip enable and with data still driven
  a_r4_we_release_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (!ce_n && dq_oe));
  // R5: address steady across a selected access
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !$past(ce_n)) |-> $stable(addr));
  // R5: write data steady while driven
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o));
  // R3: read-valid is a single-cycle pulse
  a_r3_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  // R7: ready only while the memory is parked
  a_r7_ready_parked: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && we_n && oe_n && !dq_oe));
  // R8: bus turnaround before driving
  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(oe_n) && $past(oe_n, 2)));
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ce_n   (sram_ce_n_o),
  .we_n   (sram_we_n_o),
  .oe_n   (sram_oe_n_o),
  .dq_oe  (sram_dq_oe_o),
  .dq_o   (sram_dq_o),
  .addr   (sram_addr_o),
  .ready  (ready_o),
  .rvalid (rvalid_o)
);

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int RD_CYC = 3;
  localparam int WR_CYC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_i, wr_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic rvalid_o, ready_o;
  logic sram_ce_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o;
  logic [AW-1:0] sram_addr_o;
  logic [DW-1:0] sram_dq_o;
  wire  [DW-1:0] sram_dq_i;

  always #5 clk = ~clk;

  sram_ctl #(.AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .ready_o(ready_o),
    .sram_ce_n_o(sram_ce_n_o), .sram_we_n_o(sram_we_n_o), .sram_oe_n_o(sram_oe_n_o),
    .sram_addr_o(sram_addr_o), .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i),
    .sram_dq_oe_o(sram_dq_oe_o)
  );

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]} ^ 8'hA5;
  endfunction

  // pin-level memory model
  logic [7:0] sram_mem [logic [17:0]];
  logic [7:0] sram_val;
  logic       sram_drv;
  assign sram_drv  = (sram_ce_n_o === 1'b0) && (sram_oe_n_o === 1'b0) && (sram_we_n_o === 1'b1);
  assign sram_dq_i = sram_drv ? sram_val : (sram_dq_oe_o ? sram_dq_o : 8'hzz);

  always @(negedge clk)
    sram_val <= sram_mem.exists(sram_addr_o) ? sram_mem[sram_addr_o] : dflt(sram_addr_o);

  always @(posedge sram_we_n_o) begin
    if (sram_ce_n_o === 1'b0) begin
      if (sram_dq_oe_o === 1'b1) sram_mem[sram_addr_o] = sram_dq_o;
      else                       sram_mem[sram_addr_o] = 8'hxx;
    end
  end

  // reference model: expected pins per cycle
  typedef struct {
    int         kind;   // 0 parked, 1 read, 2 write
    logic [3:0] pins;   // {ce_n, we_n, oe_n, drive}
    logic       rdy;
    logic       rv;
    logic [17:0] a;
    logic [7:0]  d;
  } exp_t;

  exp_t       q[$];
  logic [7:0] ref_mem [logic [17:0]];
  logic [7:0] last_rd;
  bit         have_rd = 0;
  int         oe_high_run = 0;
  logic       prev_drv = 1'b0;

  function automatic exp_t mk(int k, logic [3:0] p, logic r, logic v,
                              logic [17:0] a, logic [7:0] d);
    exp_t e;
    e.kind = k; e.pins = p; e.rdy = r; e.rv = v; e.a = a; e.d = d;
    return e;
  endfunction

  task automatic plan_op(input logic w, input logic [17:0] a, input logic [7:0] d);
    if (!w) begin
      logic [7:0] rd;
      rd = ref_mem.exists(a) ? ref_mem[a] : dflt(a);
      repeat (RD_CYC) q.push_back(mk(1, 4'b0100, 1'b0, 1'b0, a, d));
      q.push_back(mk(0, 4'b1110, 1'b1, 1'b1, a, rd));
    end else begin
      ref_mem[a] = d;
      q.push_back(mk(2, 4'b0110, 1'b0, 1'b0, a, d));
      q.push_back(mk(2, 4'b0010, 1'b0, 1'b0, a, d));
      repeat (WR_CYC) q.push_back(mk(2, 4'b0011, 1'b0, 1'b0, a, d));
      q.push_back(mk(2, 4'b0111, 1'b0, 1'b0, a, d));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      exp_t e;
      logic [3:0] act;
      if (q.size() > 0) e = q.pop_front();
      else e = mk(0, 4'b1110, 1'b1, 1'b0, '0, '0);
      act = {sram_ce_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o};
      if (e.kind == 1)      chk("R2 read strobes", act, e.pins);
      else if (e.kind == 2) chk("R4 write strobes", act, e.pins);
      else                  chk("R1 parked strobes", act, e.pins);
      chk("R7 ready", ready_o, e.rdy);
      chk("R3 rvalid", rvalid_o, e.rv);
      if (e.kind != 0) chk("R5 address", sram_addr_o, e.a);
      if (e.pins[0]) chk("R5 write data", sram_dq_o, e.d);
      if (e.rv) begin
        chk("R3 read data", rdata_o, e.d);
        last_rd = e.d;
        have_rd = 1;
      end else if (have_rd) begin
        chk("R9 read data held", rdata_o, last_rd);
      end
      if (sram_drv && sram_dq_oe_o) chk("R6 bus contention", 1, 0);
      if (sram_dq_oe_o && !prev_drv) chk("R8 turnaround cycles", (oe_high_run >= 2), 1);
      prev_drv    = sram_dq_oe_o;
      oe_high_run = sram_oe_n_o ? oe_high_run + 1 : 0;
      if (e.rdy && req_i) plan_op(wr_i, addr_i, wdata_i);
    end
  end

  // stimulus helpers: called just after a rising edge
  task automatic issue(input logic w, input logic [17:0] a, input logic [7:0] d);
    req_i = 1'b1; wr_i = w; addr_i = a; wdata_i = d;
    do @(negedge clk); while (ready_o !== 1'b1);
    @(posedge clk); #1;
    req_i = 1'b0; wr_i = ~w; addr_i = ~a; wdata_i = ~d;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset strobes", {sram_ce_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o}, 4'b1110);
    chk("R1 reset ready", ready_o, 1'b1);
    chk("R1 reset rvalid", rvalid_o, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(5);

    // boundary addresses (R4, R3)
    issue(1'b1, 18'h00000, 8'h3C);
    idle(2);
    issue(1'b0, 18'h00000, 8'h00);
    idle(2);
    issue(1'b1, 18'h3FFFF, 8'hC3);
    issue(1'b0, 18'h3FFFF, 8'h00);
    // unwritten location
    issue(1'b0, 18'h12345, 8'h00);
    idle(1);
    // write right after read (R8), requests held while busy (R7, R5)
    issue(1'b0, 18'h00000, 8'h00);
    issue(1'b1, 18'h00001, 8'h5A);
    issue(1'b1, 18'h00001, 8'hA5);
    issue(1'b0, 18'h00001, 8'h00);
    idle(4);
    // R9: writes and idle do not alter rdata
    issue(1'b1, 18'h2AAAA, 8'hFF);
    idle(3);
    issue(1'b0, 18'h2AAAA, 8'h00);
    // mixed traffic
    for (int i = 0; i < 40; i++) begin
      logic [17:0] a;
      a = 18'((i * 7919) % 64) ^ 18'h20000;
      issue(((i % 3) != 0), a, 8'(i * 37 + 11));
      if ((i % 5) == 0) idle(i % 4);
    end
    for (int i = 0; i < 64; i++) issue(1'b0, 18'(i) ^ 18'h20000, 8'h00);
    idle(10);
    chk("R7 queue drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule